// File: doc/BRIEF.md
# 64-Source Priority Interrupt Controller

This block gathers 64 interrupt lines into one request to a processor. Each line has a setup word that picks level or rising-edge sensitivity and gives it a priority from 0 to 7. Software unmasks lines by writing ones to an enable register and masks them by writing ones to a disable register. There is one such pair for lines 0 to 31 and another for lines 32 to 63. Software reads a vector register to learn which line to service. A value of 64 in that register means nothing is pending and the read is spurious.

Writing the end-of-interrupt register releases a latched edge on the line the vector currently names. A second way to drop a stale edge is to rewrite a line's setup word with the edge bit cleared and then set it again. A global enable bit gates the request output. A self-clearing reset bit returns every register to zero.

The CPU side is a simple 32-bit register port: a select, a write strobe, a 10-bit byte address and write data, with combinational read data.

Top module: `irqctl_top`

## Requirements
- R1: After reset every line is masked, level sensitive, at priority 0, with global enable off. The vector reads 64 and `irq_req` is low.
- R2: Writing a 1 to bit b of the enable-low register (0x000) unmasks line b, and of the enable-high register (0x004) unmasks line b+32. Zero bits leave their lines unchanged. Reading either address returns that half's mask state, with 1 meaning enabled.
- R3: Writing a 1 to bit b of the disable-low register (0x008) masks line b, and of the disable-high register (0x00C) masks line b+32. Zero bits leave their lines unchanged.
- R4: Line n has a setup word at byte address 0x200 + 8·n. Bits [2:0] hold the priority and bit 8 selects edge mode. The word reads back as written.
- R5: In level mode a line is pending exactly while its input is high.
- R6: In edge mode a rising input is latched as pending and stays pending after the input falls.
- R7: The vector register (0x018) gives the enabled, pending line with the highest priority, with ties going to the lowest line number. It gives 64 when no enabled line is pending. It follows its inputs with one register of delay.
- R8: Any write to the end-of-interrupt register (0x01C) clears the edge latch of the line the vector names. If a new rising edge reaches that line in the same cycle, the line stays pending. A level line named by the vector is not affected.
- R9: Writing a setup word with bit 8 clear discards that line's edge latch, so toggling the edge bit off and back on drops a stale edge. Rewriting a setup word with bit 8 still set keeps the latch.
- R10: `irq_req` is registered. It is high one cycle after global enable (bit 0 of 0x024, readable) is set while an enabled line is pending. It is never high while global enable is clear.
- R11: Writing 1 to bit 0 of the reset register (0x020) zeroes all masks, setup words, edge latches and global enable, and drops `irq_req`. Writing 0 there has no effect. The register always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while selected for a read |
| irq_in | input | 64 | Interrupt lines, synchronous to clk |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The delicate collision is an end-of-interrupt write landing in the same clock edge as a fresh rising edge on the line being acknowledged. If the clear wins, that new interrupt is silently lost. The bench drives the end-of-interrupt write and the rising input on the same negative edge, lets the line fall again, and then expects the vector still to name that edge line rather than the lower-priority level line behind it. A plain end-of-interrupt write immediately afterwards must then expose the level line, which shows the clear itself still works.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;

    localparam int PRIO_W   = 3;
    localparam int HALF_W   = 32;
    localparam int ADDR_W   = 10;
    localparam int EDGE_BIT = 8;

    localparam logic [ADDR_W-1:0] OFS_ENA_LO = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_ENA_HI = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_DIS_LO = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_DIS_HI = 10'h00C;
    localparam logic [ADDR_W-1:0] OFS_VEC    = 10'h018;
    localparam logic [ADDR_W-1:0] OFS_EOI    = 10'h01C;
    localparam logic [ADDR_W-1:0] OFS_SRST   = 10'h020;
    localparam logic [ADDR_W-1:0] OFS_GEN    = 10'h024;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic  edge_sel;
        prio_t prio;
    } setup_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ENA,
        ACC_DIS,
        ACC_VEC,
        ACC_EOI,
        ACC_SRST,
        ACC_GEN,
        ACC_SETUP
    } acc_e;

    function automatic setup_t unpack_setup(logic [31:0] w);
        setup_t s;
        s.edge_sel = w[EDGE_BIT];
        s.prio     = w[PRIO_W-1:0];
        return s;
    endfunction

    function automatic logic [31:0] pack_setup(setup_t s);
        logic [31:0] w;
        w               = '0;
        w[EDGE_BIT]     = s.edge_sel;
        w[PRIO_W-1:0]   = s.prio;
        return w;
    endfunction

endpackage

// File: rtl/irqctl_src.sv
module irqctl_src
    import irqctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_i,
    input  logic   in_i,
    input  logic   en_set_i,
    input  logic   en_clr_i,
    input  logic   setup_wr_i,
    input  setup_t setup_i,
    input  logic   eoi_hit_i,
    output logic   en_o,
    output setup_t setup_o,
    output logic   pend_o
);

    logic   en_q;
    setup_t setup_q;
    logic   latch_q;
    logic   prev_q;
    logic   rise;
    logic   latch_d;

    assign rise = in_i & ~prev_q;

    // Edge latch: level mode or a write that drops the edge bit discards it;
    // end-of-interrupt clears it, but a coincident new rise keeps it set.
    always_comb begin
        if (!setup_q.edge_sel || (setup_wr_i && !setup_i.edge_sel)) begin
            latch_d = 1'b0;
        end else if (eoi_hit_i) begin
            latch_d = rise;
        end else begin
            latch_d = latch_q | rise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= in_i;
        end
    end

    always_ff @(posedge clk) begin
        if (clr_i) begin
            en_q    <= 1'b0;
            setup_q <= '0;
            latch_q <= 1'b0;
        end else begin
            if (en_set_i) begin
                en_q <= 1'b1;
            end else if (en_clr_i) begin
                en_q <= 1'b0;
            end
            if (setup_wr_i) begin
                setup_q <= setup_i;
            end
            latch_q <= latch_d;
        end
    end

    assign en_o    = en_q;
    assign setup_o = setup_q;
    assign pend_o  = setup_q.edge_sel ? latch_q : in_i;

    assert_en_set_R2: assert property (@(posedge clk) disable iff (rst)
        (en_set_i && !clr_i) |=> en_q);

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (en_clr_i && !en_set_i) |=> !en_q);

    assert_edge_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (setup_q.edge_sel && latch_q && !clr_i && !eoi_hit_i && !setup_wr_i) |=> latch_q);

    assert_eoi_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (setup_q.edge_sel && eoi_hit_i && in_i && !prev_q && !clr_i && !setup_wr_i) |=> latch_q);

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!en_q && setup_q == '0 && !latch_q));

endmodule

// File: rtl/irqctl_arb.sv
module irqctl_arb
    import irqctl_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     act_i,
    input  prio_t            prio_i [N],
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);

    prio_t best;

    // Scan from the top line down; ">=" lets a lower line take over on a tie.
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        best  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i] && (!vld_o || prio_i[i] >= best)) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(i);
                best  = prio_i[i];
            end
        end
    end

    assert_win_active_R7: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> act_i[idx_o]);

    assert_idle_empty_R7: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> (act_i == '0));

endmodule

// File: rtl/irqctl_top.sv
module irqctl_top
    import irqctl_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               irq_req
);

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int VEC_W = IDX_W + 1;
    localparam logic [VEC_W-1:0] VEC_IDLE = VEC_W'(NUM_SRC);

    acc_e             acc;
    logic             hsel;
    logic [IDX_W-1:0] sidx;
    logic             wr;
    logic             soft_clr;
    logic             clr;
    logic             eoi_wr;
    logic             gen_q;
    logic [VEC_W-1:0] vec_q;
    setup_t           setup_wd;

    logic [NUM_SRC-1:0] en_v;
    logic [NUM_SRC-1:0] pend_v;
    logic [NUM_SRC-1:0] act_v;
    setup_t             setup_v [NUM_SRC];
    prio_t              prio_v  [NUM_SRC];
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;

    assign hsel     = bus_addr[2];
    assign sidx     = bus_addr[3 +: IDX_W];
    assign setup_wd = unpack_setup(bus_wdata);

    always_comb begin
        acc = ACC_NONE;
        if (bus_sel) begin
            if (bus_addr[ADDR_W-1]) begin
                if (bus_addr[2:0] == 3'b000) begin
                    acc = ACC_SETUP;
                end
            end else begin
                case (bus_addr)
                    OFS_ENA_LO, OFS_ENA_HI: acc = ACC_ENA;
                    OFS_DIS_LO, OFS_DIS_HI: acc = ACC_DIS;
                    OFS_VEC:                acc = ACC_VEC;
                    OFS_EOI:                acc = ACC_EOI;
                    OFS_SRST:               acc = ACC_SRST;
                    OFS_GEN:                acc = ACC_GEN;
                    default:                acc = ACC_NONE;
                endcase
            end
        end
    end

    assign wr       = bus_sel & bus_wr;
    assign soft_clr = wr && (acc == ACC_SRST) && bus_wdata[0];
    assign clr      = rst | soft_clr;
    assign eoi_wr   = wr && (acc == ACC_EOI);

    always_ff @(posedge clk) begin
        if (clr) begin
            gen_q <= 1'b0;
        end else if (wr && acc == ACC_GEN) begin
            gen_q <= bus_wdata[0];
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int H = i / HALF_W;
        localparam int B = i % HALF_W;
        logic en_set;
        logic en_clr;
        logic set_wr;
        logic eoi_hit;

        assign en_set  = wr && (acc == ACC_ENA) && (int'(hsel) == H) && bus_wdata[B];
        assign en_clr  = wr && (acc == ACC_DIS) && (int'(hsel) == H) && bus_wdata[B];
        assign set_wr  = wr && (acc == ACC_SETUP) && (sidx == IDX_W'(i));
        assign eoi_hit = eoi_wr && (vec_q == VEC_W'(i));

        irqctl_src u_src (
            .clk        (clk),
            .rst        (rst),
            .clr_i      (clr),
            .in_i       (irq_in[i]),
            .en_set_i   (en_set),
            .en_clr_i   (en_clr),
            .setup_wr_i (set_wr),
            .setup_i    (setup_wd),
            .eoi_hit_i  (eoi_hit),
            .en_o       (en_v[i]),
            .setup_o    (setup_v[i]),
            .pend_o     (pend_v[i])
        );

        assign prio_v[i] = setup_v[i].prio;
    end

    assign act_v = pend_v & en_v;

    irqctl_arb #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act_v),
        .prio_i (prio_v),
        .vld_o  (win_vld),
        .idx_o  (win_idx)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            vec_q   <= VEC_IDLE;
            irq_req <= 1'b0;
        end else begin
            vec_q   <= win_vld ? {1'b0, win_idx} : VEC_IDLE;
            irq_req <= gen_q & (|act_v);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (acc)
                ACC_ENA:   bus_rdata = en_v[{hsel, 5'b00000} +: HALF_W];
                ACC_VEC:   bus_rdata = 32'(vec_q);
                ACC_GEN:   bus_rdata = {31'b0, gen_q};
                ACC_SETUP: bus_rdata = pack_setup(setup_v[sidx]);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_req_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !gen_q |=> !irq_req);

    assert_req_has_vec_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (vec_q < VEC_IDLE));

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (!gen_q && !irq_req && vec_q == VEC_IDLE));

endmodule

// File: tb/test_irqctl_top.sv
module test_irqctl_top;

    logic        clk;
    logic        rst;
    logic        sel;
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [63:0] irq_in;
    logic        irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int prio_m [64];

    irqctl_top i_irqctl_top (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_in    (irq_in),
        .irq_req   (irq_req)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (R1..R11 run): actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic br(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(int n);
        @(negedge clk); irq_in[n] = 1'b1;
        @(negedge clk); irq_in[n] = 1'b0;
    endtask

    function automatic int exp_win(logic [63:0] a);
        int best = -1;
        for (int i = 0; i < 64; i++) begin
            if (a[i] && (best < 0 || prio_m[i] > prio_m[best])) best = i;
        end
        return (best < 0) ? 64 : best;
    endfunction

    function automatic logic [9:0] setup_addr(int n);
        return 10'(32'h200 + 8 * n);
    endfunction

    initial begin
        logic [31:0] d;
        logic [63:0] pat;
        logic [63:0] enmask;

        rst = 1'b1; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; irq_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        br(10'h018, d); chk("R1 vector idle", 64'(d), 64);
        br(10'h000, d); chk("R1 mask low", 64'(d), 0);
        br(10'h004, d); chk("R1 mask high", 64'(d), 0);
        br(10'h024, d); chk("R1 global enable", 64'(d), 0);
        br(setup_addr(0), d);  chk("R1 setup 0", 64'(d), 0);
        br(setup_addr(63), d); chk("R1 setup 63", 64'(d), 0);
        chk("R1 irq_req", 64'(irq_req), 0);

        // R4 setup words, swept over every line
        for (int n = 0; n < 64; n++) begin
            prio_m[n] = (n * 5 + 3) % 8;
            bw(setup_addr(n), 32'(prio_m[n]));
            br(setup_addr(n), d);
            chk("R4 setup readback", 64'(d), 64'(prio_m[n]));
        end
        bw(setup_addr(33), 32'h105);
        br(setup_addr(33), d); chk("R4 edge bit readback", 64'(d), 64'h105);
        bw(setup_addr(33), 32'(prio_m[33]));

        // R2 / R3 write-one set and clear
        bw(10'h000, 32'hA5A5_5A5A);
        br(10'h000, d); chk("R2 enable low", 64'(d), 64'hA5A5_5A5A);
        bw(10'h000, 32'h0);
        br(10'h000, d); chk("R2 zero bits no effect", 64'(d), 64'hA5A5_5A5A);
        bw(10'h004, 32'h0000_FFFF);
        bw(10'h004, 32'hFFFF_0000);
        br(10'h004, d); chk("R2 enable high accumulates", 64'(d), 64'hFFFF_FFFF);
        bw(10'h008, 32'h0000_00FF);
        br(10'h000, d); chk("R3 disable low", 64'(d), 64'hA5A5_5A00);
        bw(10'h008, 32'h0);
        br(10'h000, d); chk("R3 zero bits no effect", 64'(d), 64'hA5A5_5A00);
        bw(10'h00C, 32'h8000_0001);
        br(10'h004, d); chk("R3 disable high", 64'(d), 64'h7FFF_FFFE);

        bw(10'h000, 32'hFFFF_FFFF);
        bw(10'h004, 32'hFFFF_FFFF);
        enmask = '1;

        // R5 level sweep, one line at a time
        for (int n = 0; n < 64; n++) begin
            irq_in = 64'(1) << n;
            settle();
            br(10'h018, d); chk("R5 level line vector", 64'(d), 64'(n));
        end
        irq_in = '0;
        settle();
        br(10'h018, d); chk("R7 idle vector", 64'(d), 64);

        // R7 ties
        irq_in = '0; irq_in[3] = 1'b1; irq_in[11] = 1'b1;
        settle(); br(10'h018, d); chk("R7 tie lowest line", 64'(d), 3);
        irq_in = '0; irq_in[11] = 1'b1; irq_in[19] = 1'b1;
        settle(); br(10'h018, d); chk("R7 tie lowest line b", 64'(d), 11);

        // R7 pattern sweep with priorities and masks
        pat = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 48; k++) begin
            if (k == 24) begin
                bw(10'h008, 32'h0F0F_0F0F);
                bw(10'h00C, 32'hF0F0_0000);
                enmask = ~{32'hF0F0_0000, 32'h0F0F_0F0F};
            end
            pat = {pat[62:0], pat[63] ^ pat[62] ^ pat[60] ^ pat[59]};
            irq_in = (k % 2 == 0) ? pat : (pat & (pat >> 7) & (pat >> 13));
            settle();
            br(10'h018, d);
            chk("R7 priority pick", 64'(d), 64'(exp_win(irq_in & enmask)));
        end
        bw(10'h000, 32'hFFFF_FFFF);
        bw(10'h004, 32'hFFFF_FFFF);

        // R10 global enable and latency
        irq_in = '0; irq_in[40] = 1'b1;
        settle();
        chk("R10 no request without enable", 64'(irq_req), 0);
        bw(10'h024, 32'h1);
        #1; chk("R10 request one cycle later", 64'(irq_req), 0);
        @(negedge clk); #1; chk("R10 request asserted", 64'(irq_req), 1);
        br(10'h024, d); chk("R10 enable readback", 64'(d), 1);
        @(negedge clk); irq_in[40] = 1'b0;
        #1; chk("R10 request held before edge", 64'(irq_req), 1);
        @(negedge clk); #1; chk("R10 request dropped", 64'(irq_req), 0);

        // R6 edge capture against a lower-priority level line
        bw(setup_addr(20), 32'h1); prio_m[20] = 1;
        bw(setup_addr(10), 32'h107); prio_m[10] = 7;
        irq_in = '0; irq_in[20] = 1'b1;
        settle(); br(10'h018, d); chk("R6 level line first", 64'(d), 20);
        pulse(10);
        settle(); br(10'h018, d); chk("R6 edge held after fall", 64'(d), 10);

        // R8 end of interrupt
        bw(10'h01C, 32'h0);
        settle(); br(10'h018, d); chk("R8 eoi clears edge", 64'(d), 20);
        bw(10'h01C, 32'h0);
        settle(); br(10'h018, d); chk("R8 eoi leaves level line", 64'(d), 20);
        pulse(10);
        settle(); br(10'h018, d); chk("R8 edge again", 64'(d), 10);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 10'h01C; wdata = '0; irq_in[10] = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; irq_in[10] = 1'b0;
        settle(); br(10'h018, d); chk("R8 same-cycle rise survives eoi", 64'(d), 10);
        bw(10'h01C, 32'h0);
        settle(); br(10'h018, d); chk("R8 plain eoi after collision", 64'(d), 20);

        // R9 edge toggle
        pulse(10);
        settle(); br(10'h018, d); chk("R9 edge latched", 64'(d), 10);
        bw(setup_addr(10), 32'h107);
        settle(); br(10'h018, d); chk("R9 rewrite keeps latch", 64'(d), 10);
        bw(setup_addr(10), 32'h007);
        bw(setup_addr(10), 32'h107);
        settle(); br(10'h018, d); chk("R9 toggle drops latch", 64'(d), 20);
        chk("R10 request with level line", 64'(irq_req), 1);

        // R11 soft reset
        bw(10'h020, 32'h0);
        br(10'h024, d); chk("R11 zero write keeps enable", 64'(d), 1);
        br(10'h000, d); chk("R11 zero write keeps masks", 64'(d), 64'hFFFF_FFFF);
        bw(10'h020, 32'h1);
        settle();
        br(10'h024, d); chk("R11 enable cleared", 64'(d), 0);
        br(10'h000, d); chk("R11 mask low cleared", 64'(d), 0);
        br(10'h004, d); chk("R11 mask high cleared", 64'(d), 0);
        br(setup_addr(10), d); chk("R11 setup cleared", 64'(d), 0);
        br(10'h018, d); chk("R11 vector idle", 64'(d), 64);
        br(10'h020, d); chk("R11 reads zero", 64'(d), 0);
        chk("R11 request low", 64'(irq_req), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule